// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Controller

This block is the master-side condition engine of an I2C port. It samples the SDA and SCL lines through a synchronizer and keeps a bus-busy flag. The flag is set when SDA falls while SCL is high, and it is cleared when SDA rises while SCL is high. The flag follows what is seen on the wires, whoever drives them.

Software controls the block through one 8-bit register. A write that sets the busy bit and clears the prohibit bit requests a start condition. If the block already holds the bus, the same write produces a repeated start. A write that clears both bits requests a stop. The SDA and SCL pins are open-drain. The block only ever pulls a line low (output enable = 1) or releases it. Each phase of a condition lasts a programmable number of clock cycles. Read-only monitor bits report the level the block itself is driving.

A self-clearing recovery bit forces the sequencer back to idle and releases both lines. It does not disturb anything else. Byte transfer, acknowledge, addressing and arbitration are outside this block.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset the register reads 0x7C. Bit 7 (busy) is 0, bits 6, 5, 4, 3 and 2 are 1, and bits 1 and 0 are 0. Both output enables are 0.
- R2: The busy flag (read bit 7) becomes 1 when synchronized SDA falls while synchronized SCL is high. The flag is first readable 3 clock edges after the line changes.
- R3: The busy flag becomes 0 when synchronized SDA rises while synchronized SCL is high, with the same 3-edge latency.
- R4: An SDA pulse that starts and ends between two sampling edges does not change the busy flag. SDA changes while SCL is low do not change the busy flag.
- R5: In idle with the bus free, a write with bit 7 = 1, bit 6 = 0 and bit 1 = 0 issues a start. From the edge that takes the write, SDA is pulled low for HOLD_CYCLES cycles with SCL released. After that, both lines stay pulled low (bus held).
- R6: The same write while the bus is held issues a repeated start in three phases of HOLD_CYCLES cycles each. First SDA is released with SCL low. Then both lines are released. Then SDA is pulled low with SCL released. The block then holds the bus again, and the busy flag stays 1.
- R7: A write with bit 7 = 0, bit 6 = 0 and bit 1 = 0 while the bus is held issues a stop in two phases of HOLD_CYCLES cycles each. First both lines are low. Then SCL is released while SDA stays low. Finally both lines are released.
- R8: A write with bit 6 = 1 produces no condition in any state. Bit 6 always reads 1, and the written bit 7 is not stored.
- R9: These requests are ignored: a start in idle while the bus is busy, a stop in idle, and any request made while a start, repeated start or stop sequence is still running.
- R10: Read bit 5 is 1 when the block releases SDA and 0 when it pulls SDA low. Read bit 3 does the same for SCL. Both bits report the driven level, not the line level.
- R11: Writing bit 1 = 1 makes bit 1 read 1 for exactly two cycles and then clear by itself. While it is 1, both lines are released. The sequencer returns to idle, and any start or stop requested in that write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |

## Verification
The bench tries the register with every written value that has the prohibit bit set, both in idle and while holding the bus. This separates prohibited writes from real requests. Start, repeated-start and stop requests are checked phase by phase against sequences computed from the hold count. Requests placed mid-sequence, in idle, or against a bus held by another master show whether the sequencer filters them. An external agent drives starts and stops, glitches between sampling edges, and toggles SDA with SCL held low. These cases separate real bus conditions from noise, and the driven level from the line level.

// File: rtl/i2c_cond_pkg.sv
// Shared types and register bit positions for the I2C condition controller.
// Assumes: one 8-bit control/status register; positions are fixed here only.
package i2c_cond_pkg;

    // Sequencer states: idle, timed phases, and the held-bus state.
    typedef enum logic [2:0] {
        G_IDLE,
        G_START,
        G_HELD,
        G_RS_SDA,
        G_RS_SCL,
        G_SP_SDA,
        G_SP_SCL
    } gen_state_e;

    localparam int BIT_BUSY = 7;
    localparam int BIT_PROH = 6;
    localparam int BIT_SDAM = 5;
    localparam int BIT_RSV4 = 4;
    localparam int BIT_SCLM = 3;
    localparam int BIT_RSV2 = 2;
    localparam int BIT_CRST = 1;
    localparam int BIT_RSV0 = 0;

endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchronizer for a bundle of bus lines.
// Assumes: idle lines are high, so every stage resets to 1.
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_i,
    output logic [WIDTH-1:0] level_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // Purpose: shift the raw lines through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else begin
            stg_q[0] <= line_i;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign level_o = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_bus_monitor.sv
// Bus-busy tracker: detects start (SDA fall, SCL high) and stop (SDA rise,
// SCL high) on synchronized lines. Assumes inputs are already synchronous.
module i2c_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    output logic busy_o
);

    logic sda_prev_q;
    logic start_det;
    logic stop_det;

    assign start_det = sda_prev_q & ~sda_i & scl_i;
    assign stop_det  = ~sda_prev_q & sda_i & scl_i;

    // Purpose: remember the previous SDA sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev_q <= 1'b1;
        else        sda_prev_q <= sda_i;
    end

    // Purpose: set busy on a start, clear it on a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_o <= 1'b0;
        else if (start_det) busy_o <= 1'b1;
        else if (stop_det)  busy_o <= 1'b0;
    end

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy_o);
    p_busy_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy_o);
    p_busy_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !stop_det) |=> $stable(busy_o));

endmodule

// File: rtl/i2c_cond_gen.sv
// Start / repeated-start / stop sequencer driving open-drain enables.
// Each timed phase lasts HOLD_CYCLES cycles. Assumes HOLD_CYCLES >= 2 and
// that request strobes are single-cycle pulses.
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic req_start_i,
    input  logic req_stop_i,
    input  logic bus_busy_i,
    output logic sda_oe_o,
    output logic scl_oe_o,
    output logic idle_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES - 1);

    gen_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic phase_done;

    assign phase_done = (cnt_q == '0);

    // Purpose: choose the next sequencer state.
    always_comb begin
        state_d = state_q;
        case (state_q)
            G_IDLE:   if (req_start_i && !bus_busy_i) state_d = G_START;
            G_START:  if (phase_done) state_d = G_HELD;
            G_HELD: begin
                if (req_start_i)     state_d = G_RS_SDA;
                else if (req_stop_i) state_d = G_SP_SDA;
            end
            G_RS_SDA: if (phase_done) state_d = G_RS_SCL;
            G_RS_SCL: if (phase_done) state_d = G_START;
            G_SP_SDA: if (phase_done) state_d = G_SP_SCL;
            G_SP_SCL: if (phase_done) state_d = G_IDLE;
            default:  state_d = G_IDLE;
        endcase
    end

    // Purpose: advance state and reload or count down the phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            state_q <= G_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= LOAD;
            else if (!phase_done)   cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: decode the open-drain enables from the state.
    always_comb begin
        sda_oe_o = 1'b0;
        scl_oe_o = 1'b0;
        case (state_q)
            G_START:  begin sda_oe_o = 1'b1; scl_oe_o = 1'b0; end
            G_HELD:   begin sda_oe_o = 1'b1; scl_oe_o = 1'b1; end
            G_RS_SDA: begin sda_oe_o = 1'b0; scl_oe_o = 1'b1; end
            G_RS_SCL: begin sda_oe_o = 1'b0; scl_oe_o = 1'b0; end
            G_SP_SDA: begin sda_oe_o = 1'b1; scl_oe_o = 1'b1; end
            G_SP_SCL: begin sda_oe_o = 1'b1; scl_oe_o = 1'b0; end
            default:  begin sda_oe_o = 1'b0; scl_oe_o = 1'b0; end
        endcase
    end

    assign idle_o = (state_q == G_IDLE);

    p_scl_after_sda_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe_o) |-> (sda_oe_o && $past(sda_oe_o)));
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
    p_idle_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == G_IDLE && req_start_i && bus_busy_i) |=> (state_q == G_IDLE));
    p_seq_ignores_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == G_SP_SDA && !phase_done && !clr_i) |=> (state_q == G_SP_SDA));

endmodule

// File: rtl/i2c_cond_ctrl.sv
// Top: register decode, recovery bit, synchronizer, bus monitor, sequencer.
// Assumes: sda_in/scl_in are asynchronous wired-AND line levels; outputs are
// active-high pull-down enables.
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       sda_oe,
    output logic       scl_oe
);

    logic [1:0] line_sync;
    logic       busy;
    logic       crst_q;
    logic       crst_done_q;
    logic       req_start;
    logic       req_stop;
    logic       gen_sda_oe;
    logic       gen_scl_oe;
    logic       gen_idle;
    logic       req_ok;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  ({scl_in, sda_in}),
        .level_o (line_sync)
    );

    i2c_bus_monitor u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .sda_i  (line_sync[0]),
        .scl_i  (line_sync[1]),
        .busy_o (busy)
    );

    // A condition request needs prohibit clear, recovery clear and idle recovery.
    assign req_ok    = wr_en && !wr_data[BIT_PROH] && !wr_data[BIT_CRST] && !crst_q;
    assign req_start = req_ok &&  wr_data[BIT_BUSY];
    assign req_stop  = req_ok && !wr_data[BIT_BUSY];

    // Purpose: recovery bit; set by write, cleared one cycle after the reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crst_q      <= 1'b0;
            crst_done_q <= 1'b0;
        end else if (crst_q && !crst_done_q) begin
            crst_done_q <= 1'b1;
        end else if (crst_q) begin
            crst_q      <= 1'b0;
            crst_done_q <= 1'b0;
        end else if (wr_en && wr_data[BIT_CRST]) begin
            crst_q      <= 1'b1;
        end
    end

    i2c_cond_gen #(.HOLD_CYCLES(HOLD_CYCLES)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (crst_q),
        .req_start_i (req_start),
        .req_stop_i  (req_stop),
        .bus_busy_i  (busy),
        .sda_oe_o    (gen_sda_oe),
        .scl_oe_o    (gen_scl_oe),
        .idle_o      (gen_idle)
    );

    assign sda_oe = gen_sda_oe && !crst_q;
    assign scl_oe = gen_scl_oe && !crst_q;

    // Purpose: assemble the read view of the register.
    always_comb begin
        rd_data           = 8'h00;
        rd_data[BIT_BUSY] = busy;
        rd_data[BIT_PROH] = 1'b1;
        rd_data[BIT_SDAM] = !sda_oe;
        rd_data[BIT_RSV4] = 1'b1;
        rd_data[BIT_SCLM] = !scl_oe;
        rd_data[BIT_RSV2] = 1'b1;
        rd_data[BIT_CRST] = crst_q;
        rd_data[BIT_RSV0] = 1'b0;
    end

    p_crst_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crst_q) |=> crst_q ##1 !crst_q);
    p_crst_idles_gen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (crst_q && crst_done_q) |-> gen_idle);
    p_prohibit_no_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_PROH] && gen_idle) |=> gen_idle);

endmodule

// File: tb/i2c_cond_ctrl_tb.sv
// Self-checking bench for i2c_cond_ctrl with a wired-AND bus model.
module i2c_cond_ctrl_tb;

    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sda_oe, scl_oe;
    logic       ext_sda = 1'b0;
    logic       ext_scl = 1'b0;
    logic       sda_in, scl_in;
    int         errors = 0;
    int         checks = 0;

    assign sda_in = !sda_oe && !ext_sda;
    assign scl_in = !scl_oe && !ext_scl;

    always #5 clk = ~clk;

    i2c_cond_ctrl #(.HOLD_CYCLES(H), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sda_in(sda_in), .scl_in(scl_in),
        .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the negedge after the taking edge.
    task automatic do_write(logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_seq(int n, logic es, logic ec, string req);
        for (int i = 0; i < n; i++) begin
            chk(req, {7'd0, sda_oe}, {7'd0, es});
            chk(req, {7'd0, scl_oe}, {7'd0, ec});
            chk("R10", {7'd0, rd_data[5]}, {7'd0, !es});
            chk("R10", {7'd0, rd_data[3]}, {7'd0, !ec});
            @(negedge clk);
        end
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", rd_data, 8'h7C);
        chk("R1", {6'd0, sda_oe, scl_oe}, 8'h00);

        // R8: every prohibited write in idle
        for (int v = 0; v < 256; v++) begin
            if (v[6] && !v[1]) begin
                do_write(8'(v));
                chk("R8", {6'd0, sda_oe, scl_oe}, 8'h00);
                chk("R8", rd_data, 8'h7C);
            end
        end

        // R9: stop in idle
        do_write(8'h00);
        expect_seq(2 * H, 1'b0, 1'b0, "R9");

        // R5: start
        do_write(8'h80);
        expect_seq(H, 1'b1, 1'b0, "R5");
        expect_seq(3, 1'b1, 1'b1, "R5");
        chk("R2", rd_data, 8'hD4);

        // R8: every prohibited write while held
        for (int v = 0; v < 256; v++) begin
            if (v[6] && !v[1]) begin
                do_write(8'(v));
                chk("R8", {6'd0, sda_oe, scl_oe}, 8'h03);
                chk("R8", rd_data, 8'hD4);
            end
        end

        // R7 with R9: stop, then a start request mid-sequence
        do_write(8'h00);
        do_write(8'h80);
        expect_seq(H - 1, 1'b1, 1'b1, "R9");
        expect_seq(H, 1'b1, 1'b0, "R7");
        expect_seq(4, 1'b0, 1'b0, "R7");
        chk("R3", rd_data, 8'h7C);

        // R6: start then repeated start
        do_write(8'h80);
        expect_seq(H, 1'b1, 1'b0, "R5");
        expect_seq(1, 1'b1, 1'b1, "R5");
        do_write(8'h80);
        expect_seq(H, 1'b0, 1'b1, "R6");
        expect_seq(H, 1'b0, 1'b0, "R6");
        expect_seq(H, 1'b1, 1'b0, "R6");
        expect_seq(4, 1'b1, 1'b1, "R6");
        chk("R6", rd_data, 8'hD4);

        // R11: recovery from held bus
        do_write(8'h42);
        chk("R11", {6'd0, rd_data[1], sda_oe | scl_oe}, 8'h02);
        @(negedge clk);
        chk("R11", {6'd0, rd_data[1], sda_oe | scl_oe}, 8'h02);
        @(negedge clk);
        chk("R11", {6'd0, rd_data[1], sda_oe | scl_oe}, 8'h00);
        wait_cyc(4);
        chk("R11", rd_data, 8'h7C);

        // R11: recovery write carrying a start request
        do_write(8'h82);
        expect_seq(2 * H, 1'b0, 1'b0, "R11");
        chk("R11", rd_data, 8'h7C);

        // R2: external start, exact latency
        ext_sda = 1'b1;
        wait_cyc(2);
        chk("R2", {7'd0, rd_data[7]}, 8'h00);
        @(negedge clk);
        chk("R2", {7'd0, rd_data[7]}, 8'h01);

        // R9: start request while another master owns the bus
        do_write(8'h80);
        expect_seq(2 * H, 1'b0, 1'b0, "R9");

        // R3: external stop, exact latency
        ext_sda = 1'b0;
        wait_cyc(2);
        chk("R3", {7'd0, rd_data[7]}, 8'h01);
        @(negedge clk);
        chk("R3", {7'd0, rd_data[7]}, 8'h00);

        // R4: glitch between sampling edges
        #1 ext_sda = 1'b1;
        #2 ext_sda = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk("R4", {7'd0, rd_data[7]}, 8'h00);
            @(negedge clk);
        end

        // R4 and R10: SDA toggles with SCL held low externally
        ext_scl = 1'b1;
        wait_cyc(3);
        chk("R10", rd_data, 8'h7C);
        ext_sda = 1'b1;
        wait_cyc(3);
        ext_sda = 1'b0;
        wait_cyc(3);
        ext_sda = 1'b1;
        wait_cyc(3);
        chk("R4", {7'd0, rd_data[7]}, 8'h00);
        ext_sda = 1'b0;
        wait_cyc(3);
        ext_scl = 1'b0;
        wait_cyc(5);
        chk("R4", rd_data, 8'h7C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule